// File: doc/BRIEF.md
# Rotating Predicate Loop Controller

This block sequences a software-pipelined loop that is written as a kernel body alone. It holds a rotating register base and one predicate per pipeline stage. On every kernel pass the predicates turn each stage of the body on or off. Iterations therefore enter the pipeline and later drain out of it without any separate ramp-up or drain code. The base steps on every pass, so an iteration that is still in flight keeps reading its own physical registers through the same logical register numbers.

Software loads a trip count and a drain-pass count with a start strobe, then sends one pass strobe per kernel pass. The controller shifts the predicate vector one stage deeper on each pass. It feeds a 1 into stage 0 while iterations remain, and a 0 afterwards. After the trip count and the drain passes are both used up, the next pass clears every predicate and raises a done flag. A combinational port translates a logical register index into a physical one within the rotating region. For a loop of N iterations and S stages, with the drain count set to S-1, the predicates are nonzero for N+S-1 passes and done rises on pass N+S.

Top module: `rpl_loop_ctrl`

## Requirements
- R1: After reset every stage predicate is 0, the rotation base is 0, done is 0, and the controller is idle.
- R2: A start strobe clears all predicates, sets the base to 0, clears done, and loads the trip count and the drain-pass count. The controller is active from the next cycle.
- R3: Each accepted pass decrements the base by one, modulo ROT_REGS, so base 0 goes to ROT_REGS-1.
- R4: The physical index equals (logical index + base) mod ROT_REGS. This holds for every logical index value the port can carry, including values at or above ROT_REGS.
- R5: On each accepted pass, predicate bit k moves to bit k+1 (stage 0 is bit 0). The new bit 0 is 1 exactly when the remaining trip count was nonzero before the pass, and in that case the remaining trip count drops by one.
- R6: During ramp-up, after k accepted passes with k below both the stage count and the trip count, exactly the low k predicate bits are 1.
- R7: Once the trip count is exhausted, each pass shifts a 0 into stage 0 and uses up one drain pass, while the later stages keep finishing the iterations already in flight.
- R8: The first pass that finds both the trip count and the drain count exhausted clears every predicate and sets done. Done stays set until the next start, and all predicates are 0 whenever done is set.
- R9: A pass strobe while the controller is idle (before any start, or after done) changes neither the predicates nor the base.
- R10: A start strobe in the same cycle as a pass strobe restarts the loop and ignores the pass, even in the middle of a running loop.
- R11: With a trip count of 0, no predicate is ever set, and done rises on pass D+1, where D is the drain-pass count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Loop-start strobe; loads the counts and clears the state |
| trip_count_i | input | CNT_W | Number of iterations to start |
| drain_passes_i | input | DRN_W | Number of drain passes after the last iteration enters |
| pass_i | input | 1 | Kernel-pass strobe |
| lreg_i | input | IDX_W | Logical register index to translate |
| stage_pred_o | output | NUM_STAGES | Stage predicates for the coming pass, bit 0 = stage 0 |
| rot_base_o | output | IDX_W | Current rotation base |
| preg_o | output | IDX_W | Physical register index for lreg_i |
| done_o | output | 1 | Loop finished; all predicates clear |

## Verification
The embedded properties are checked on every cycle. They cover the one-position predicate shift on each pass, the modular base step, the range and consistency of the index fold, the clearing effect of start, the idle hold, and the rule that done always comes with empty predicates. Only the directed scenarios can show that whole loops come out right. That means the exact ramp-up and drain patterns for given trip and drain counts, the pass on which done rises, zero-trip loops, a truncated drain, and the base wrapping more than once over a long loop. The scenarios also check a restart that collides with a pass, and the full logical-to-physical table, including out-of-region indices.

// File: rtl/rpl_pkg.sv
package rpl_pkg;

   // True when v is a nonzero power of two.
   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/rpl_trip_ctr.sv
// Remaining-iteration and drain-pass counters plus loop activity state.
module rpl_trip_ctr #(
   parameter int CNT_W = 8,
   parameter int DRN_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] trip_i,
   input  logic [DRN_W-1:0] drain_i,
   input  logic             adv_i,
   output logic             active_o,
   output logic             issue_o,
   output logic             finish_o,
   output logic             done_o
);

   logic [CNT_W-1:0] left_q;
   logic [DRN_W-1:0] drain_q;
   logic             active_q;
   logic             done_q;

   assign issue_o  = (left_q != '0);
   assign finish_o = adv_i && (left_q == '0) && (drain_q == '0);
   assign active_o = active_q;
   assign done_o   = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q   <= '0;
         drain_q  <= '0;
         active_q <= 1'b0;
         done_q   <= 1'b0;
      end else if (start_i) begin
         left_q   <= trip_i;
         drain_q  <= drain_i;
         active_q <= 1'b1;
         done_q   <= 1'b0;
      end else if (adv_i) begin
         if (left_q != '0) begin
            left_q <= left_q - 1'b1;
         end else if (drain_q != '0) begin
            drain_q <= drain_q - 1'b1;
         end else begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
         end
      end
   end

   // R8: done persists until a new start
   a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
      done_q && !start_i |=> done_q);

   // R7: no new iteration can be issued once draining has begun
   a_r7_no_reissue: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i && !issue_o && !start_i |=> !issue_o);

   // R9: counters are frozen while idle
   a_r9_ctr_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !active_q && !start_i |=> $stable(left_q) && $stable(drain_q));

endmodule

// File: rtl/rpl_pred_shift.sv
// Stage predicate chain: one flop per stage, shifted toward later stages.
module rpl_pred_shift #(
   parameter int NUM_STAGES = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clear_i,
   input  logic                  kill_i,
   input  logic                  adv_i,
   input  logic                  in_bit_i,
   output logic [NUM_STAGES-1:0] pred_o
);

   for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
      logic nxt;
      logic q;
      if (k == 0) begin : g_head
         assign nxt = in_bit_i;
      end else begin : g_link
         assign nxt = pred_o[k-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= 1'b0;
         end else if (clear_i || kill_i) begin
            q <= 1'b0;
         end else if (adv_i) begin
            q <= nxt;
         end
      end
      assign pred_o[k] = q;
   end

   // R5: each normal pass moves every predicate one stage deeper
   a_r5_shift: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i && !kill_i && !clear_i |=>
         (pred_o[NUM_STAGES-1:1] == $past(pred_o[NUM_STAGES-2:0])) &&
         (pred_o[0] == $past(in_bit_i)));

   // R8: the finishing pass empties the chain
   a_r8_kill_clears: assert property (@(posedge clk) disable iff (!rst_n)
      kill_i |=> pred_o == '0);

endmodule

// File: rtl/rpl_rot_base.sv
// Rotation base register and logical-to-physical index fold.
module rpl_rot_base #(
   parameter int ROT_REGS = 12,
   parameter int IDX_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             adv_i,
   input  logic [IDX_W-1:0] lreg_i,
   output logic [IDX_W-1:0] base_o,
   output logic [IDX_W-1:0] preg_o
);

   localparam logic [IDX_W-1:0] TOP = IDX_W'(ROT_REGS - 1);

   logic [IDX_W-1:0] base_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
      end else if (clear_i) begin
         base_q <= '0;
      end else if (adv_i) begin
         base_q <= (base_q == '0) ? TOP : base_q - 1'b1;
      end
   end

   assign base_o = base_q;

   if (rpl_pkg::is_pow2(ROT_REGS)) begin : g_pow2
      // Region fills the index space: wrap is plain truncation.
      assign preg_o = IDX_W'(lreg_i + base_q);
   end else begin : g_fold
      // Sum stays below 3*ROT_REGS, so two conditional subtracts reduce it.
      localparam logic [IDX_W:0] RW = (IDX_W+1)'(ROT_REGS);
      logic [IDX_W:0] s0, s1, s2;
      always_comb begin
         s0 = {1'b0, lreg_i} + {1'b0, base_q};
         s1 = (s0 >= RW) ? s0 - RW : s0;
         s2 = (s1 >= RW) ? s1 - RW : s1;
      end
      assign preg_o = s2[IDX_W-1:0];

      // R4: folded value lies inside the rotating region
      a_r4_fold_range: assert property (@(posedge clk) disable iff (!rst_n)
         s2 < RW);
   end

   // R3: each pass steps the base down by one with wrap
   a_r3_base_step: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i && !clear_i |=>
         base_q == (($past(base_q) == '0) ? TOP : IDX_W'($past(base_q) - 1'b1)));

   // R4: the base never leaves the region
   a_r4_base_range: assert property (@(posedge clk) disable iff (!rst_n)
      base_q <= TOP);

endmodule

// File: rtl/rpl_loop_ctrl.sv
// Kernel-only software-pipelined loop controller with rotating predicates.
module rpl_loop_ctrl #(
   parameter int NUM_STAGES = 4,
   parameter int ROT_REGS   = 12,
   parameter int CNT_W      = 8,
   parameter int IDX_W      = $clog2(ROT_REGS),
   parameter int DRN_W      = $clog2(NUM_STAGES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic [CNT_W-1:0]      trip_count_i,
   input  logic [DRN_W-1:0]      drain_passes_i,
   input  logic                  pass_i,
   input  logic [IDX_W-1:0]      lreg_i,
   output logic [NUM_STAGES-1:0] stage_pred_o,
   output logic [IDX_W-1:0]      rot_base_o,
   output logic [IDX_W-1:0]      preg_o,
   output logic                  done_o
);

   // Elaboration-time parameter checks
   if (NUM_STAGES < 2) begin : g_bad_stages
      $error("rpl_loop_ctrl: NUM_STAGES must be at least 2");
   end
   if (ROT_REGS < 2) begin : g_bad_regs
      $error("rpl_loop_ctrl: ROT_REGS must be at least 2");
   end
   if (IDX_W != $clog2(ROT_REGS)) begin : g_bad_idx
      $error("rpl_loop_ctrl: IDX_W must equal clog2(ROT_REGS)");
   end
   if (DRN_W != $clog2(NUM_STAGES)) begin : g_bad_drn
      $error("rpl_loop_ctrl: DRN_W must equal clog2(NUM_STAGES)");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("rpl_loop_ctrl: CNT_W must be positive");
   end

   logic active, issue, finish, adv;

   // A start in the same cycle wins over a pass (R10).
   assign adv = pass_i && active && !start_i;

   rpl_trip_ctr #(.CNT_W(CNT_W), .DRN_W(DRN_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .trip_i   (trip_count_i),
      .drain_i  (drain_passes_i),
      .adv_i    (adv),
      .active_o (active),
      .issue_o  (issue),
      .finish_o (finish),
      .done_o   (done_o)
   );

   rpl_pred_shift #(.NUM_STAGES(NUM_STAGES)) u_pred (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (start_i),
      .kill_i   (finish),
      .adv_i    (adv),
      .in_bit_i (issue),
      .pred_o   (stage_pred_o)
   );

   rpl_rot_base #(.ROT_REGS(ROT_REGS), .IDX_W(IDX_W)) u_base (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (start_i),
      .adv_i   (adv),
      .lreg_i  (lreg_i),
      .base_o  (rot_base_o),
      .preg_o  (preg_o)
   );

   // R8: done always comes with an empty predicate vector
   a_r8_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> stage_pred_o == '0);

   // R2: start leaves a clean state behind
   a_r2_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (stage_pred_o == '0) && (rot_base_o == '0) && !done_o);

   // R9: passes while idle leave predicates and base untouched
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !active && !start_i |=> $stable(stage_pred_o) && $stable(rot_base_o));

endmodule

// File: tb/tb_rpl_loop_ctrl.sv
`timescale 1ns/1ps
module tb_rpl_loop_ctrl;

   localparam int S  = 4;
   localparam int R  = 12;
   localparam int CW = 8;
   localparam int IW = $clog2(R);
   localparam int DW = $clog2(S);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [CW-1:0] trip_count_i = '0;
   logic [DW-1:0] drain_passes_i = '0;
   logic          pass_i = 1'b0;
   logic [IW-1:0] lreg_i = '0;
   logic [S-1:0]  stage_pred_o;
   logic [IW-1:0] rot_base_o;
   logic [IW-1:0] preg_o;
   logic          done_o;

   always #10 clk = ~clk;   // 50 MHz

   rpl_loop_ctrl #(.NUM_STAGES(S), .ROT_REGS(R), .CNT_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .trip_count_i(trip_count_i),
      .drain_passes_i(drain_passes_i), .pass_i(pass_i), .lreg_i(lreg_i),
      .stage_pred_o(stage_pred_o), .rot_base_o(rot_base_o), .preg_o(preg_o),
      .done_o(done_o));

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 0;

   // Reference state built from the requirements
   bit       m_active = 0;
   int       m_left = 0;
   int       m_drain = 0;
   logic [S-1:0] m_pred = '0;
   int       m_base = 0;
   bit       m_done = 0;

   task automatic chk(string req, int act, int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_state(string req);
      chk({req, " pred"}, int'(stage_pred_o), int'(m_pred));
      chk({req, " base"}, int'(rot_base_o), m_base);
      chk({req, " done"}, int'(done_o), int'(m_done));
   endtask

   task automatic model_pass();
      if (m_active) begin
         m_base = (m_base == 0) ? R - 1 : m_base - 1;
         if (m_left != 0) begin
            m_pred = {m_pred[S-2:0], 1'b1};
            m_left--;
         end else if (m_drain != 0) begin
            m_pred = {m_pred[S-2:0], 1'b0};
            m_drain--;
         end else begin
            m_pred = '0;
            m_done = 1;
            m_active = 0;
         end
      end
   endtask

   task automatic do_start(int n, int d, bit with_pass, string req);
      @(negedge clk);
      start_i = 1'b1; pass_i = with_pass;
      trip_count_i = CW'(n); drain_passes_i = DW'(d);
      m_active = 1; m_left = n; m_drain = d;
      m_pred = '0; m_base = 0; m_done = 0;
      @(negedge clk);
      start_i = 1'b0; pass_i = 1'b0;
      chk_state(req);
   endtask

   task automatic do_pass(string req);
      @(negedge clk);
      pass_i = 1'b1;
      model_pass();
      @(negedge clk);
      pass_i = 1'b0;
      chk_state(req);
   endtask

   task automatic sweep_map(string req);
      for (int lr = 0; lr < (1 << IW); lr++) begin
         lreg_i = IW'(lr);
         #1;
         chk(req, int'(preg_o), (lr + m_base) % R);
      end
   endtask

   // R1
   task automatic t_reset();
      chk_state("R1 reset");
   endtask

   // R9: passes before any start
   task automatic t_idle_before();
      for (int i = 0; i < 3; i++) do_pass("R9 idle before start");
   endtask

   // R5 R6 R7 R8 R9: full loop of 6 iterations with full drain
   task automatic t_normal();
      do_start(6, S - 1, 0, "R2 start");
      do_pass("R6 ramp1"); chk("R6 ramp1 literal", int'(stage_pred_o), 4'b0001);
      do_pass("R6 ramp2"); chk("R6 ramp2 literal", int'(stage_pred_o), 4'b0011);
      do_pass("R6 ramp3"); chk("R6 ramp3 literal", int'(stage_pred_o), 4'b0111);
      for (int i = 4; i <= 6; i++) do_pass("R5 kernel");
      chk("R5 full literal", int'(stage_pred_o), 4'b1111);
      do_pass("R7 drain1"); chk("R7 drain1 literal", int'(stage_pred_o), 4'b1110);
      do_pass("R7 drain2");
      do_pass("R7 drain3"); chk("R7 drain3 literal", int'(stage_pred_o), 4'b1000);
      chk("R8 not yet done", int'(done_o), 0);
      do_pass("R8 finish");
      chk("R8 done literal", int'(done_o), 1);
      chk("R3 base after 10 passes", int'(rot_base_o), 2);
      for (int i = 0; i < 2; i++) do_pass("R9 idle after done");
   endtask

   // R4: mapping across several bases
   task automatic t_map();
      do_start(4, S - 1, 0, "R2 start map");
      sweep_map("R4 map base0");
      do_pass("R4 step");
      sweep_map("R4 map base11");
      for (int i = 0; i < 5; i++) do_pass("R4 step");
      sweep_map("R4 map base6");
   endtask

   // R11: zero trips
   task automatic t_zero_trip();
      do_start(0, 2, 0, "R2 start zero");
      do_pass("R11 pass1"); do_pass("R11 pass2");
      chk("R11 no done yet", int'(done_o), 0);
      do_pass("R11 pass3");
      chk("R11 done after D+1", int'(done_o), 1);
      chk("R11 preds empty", int'(stage_pred_o), 0);
   endtask

   // R10: restart colliding with a pass mid-loop
   task automatic t_restart();
      do_start(5, S - 1, 0, "R2 start restart");
      for (int i = 0; i < 3; i++) do_pass("R5 pre-restart");
      do_start(2, S - 1, 1, "R10 restart with pass");
      chk("R10 base zero", int'(rot_base_o), 0);
      chk("R10 preds zero", int'(stage_pred_o), 0);
      for (int i = 0; i < 2 + S; i++) do_pass("R10 run after restart");
      chk("R10 done", int'(done_o), 1);
   endtask

   // R7 R8: truncated drain
   task automatic t_short_drain();
      do_start(3, 1, 0, "R2 start short");
      for (int i = 0; i < 3; i++) do_pass("R6 short ramp");
      do_pass("R7 short drain"); chk("R7 short literal", int'(stage_pred_o), 4'b1110);
      do_pass("R8 truncated finish");
      chk("R8 truncated clears", int'(stage_pred_o), 0);
      chk("R8 truncated done", int'(done_o), 1);
   endtask

   // R3: long loop wraps the base twice
   task automatic t_long();
      do_start(20, S - 1, 0, "R2 start long");
      for (int i = 0; i < 20 + S; i++) do_pass("R3 long loop");
      chk("R3 long done", int'(done_o), 1);
      chk("R3 long base", int'(rot_base_o), 0);
      sweep_map("R4 map after long");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_idle_before();
      t_normal();
      t_map();
      t_zero_trip();
      t_restart();
      t_short_drain();
      t_long();
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule